// File: doc/BRIEF.md
# Composite Monochrome Video Timing Generator

This block derives the timing of a 525-line, roughly 30 Hz monochrome composite frame from a fixed 8 MHz system clock. It has a pixel counter, which counts clocks within a scan line, and a line counter, which counts lines within the frame. A level decoder turns the two counts into a 2-bit code. An external resistor network converts that code into three analog levels: sync at 0 V, black near 0.3 V and white near 1.0 V.

The decoder places the horizontal sync pulse at the start of every ordinary line. The first lines of the frame are vertical sync lines, which stay at the sync level for nearly the whole line. Everything outside the visible window is held at black. Inside the window the block shows a checkerboard test image. The image is replaced by a one-bit external pixel stream whenever that source is enabled.

Both counters are brought out, so a pixel source can locate the beam position on screen.

Top module: `cvid_timing_gen`

## Requirements
- R1: The level output uses 2'b00 for sync, 2'b01 for black and 2'b11 for white. The code 2'b10 never appears.
- R2: The pixel counter advances by one on each clock from 0 to LINE_CLKS-1 (default 508 clocks, about 63.5 us at 8 MHz) and then returns to 0.
- R3: The line counter advances by one on the clock where the pixel counter wraps, and returns to 0 after FRAME_LINES-1 (default 525). At 8 MHz this gives a frame period of about 33.3 ms, which is about 30 Hz.
- R4: When rst_n is low at a rising clock edge, both counters are 0 after that edge (synchronous, active-low).
- R5: On any line that is not a vertical sync line, pixels 0 to HSYNC_CLKS-1 (default 38, about 4.7 us) output sync.
- R6: On vertical sync lines 0 to VSYNC_LINES-1 (default 3), the output is sync for pixels below LINE_CLKS-HSYNC_CLKS and black for the remaining pixels of the line.
- R7: Outside sync, the output is black wherever the pixel lies outside [HSYNC_CLKS+BPORCH_CLKS, HSYNC_CLKS+BPORCH_CLKS+ACTIVE_CLKS) or the line lies outside [VTOP_LINES, VTOP_LINES+ACTIVE_LINES).
- R8: In the visible window, with ext_en_i low, the output is white when bit 5 of the pixel counter XOR bit 5 of the line counter is 1, and black otherwise. This gives cells 32 clocks wide and 32 lines tall.
- R9: In the visible window, with ext_en_i high, the output is white when ext_white_i is 1 and black when it is 0, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (8 MHz in the target) |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_en_i | input | 1 | Selects the external pixel stream instead of the checkerboard |
| ext_white_i | input | 1 | External pixel value: 1 white, 0 black |
| level_o | output | 2 | Composite level code (00 sync, 01 black, 11 white) |
| line_o | output | $clog2(FRAME_LINES) | Current line number |
| pix_o | output | $clog2(LINE_CLKS) | Current clock position within the line |

## Verification
The hardest states to reach are the frame-level ones: the line counter wrapping from the last line to line 0, and the visible window entered after a mid-frame reset. At the default size a frame is longer than any practical run. The bench therefore drives a second, reduced-geometry instance whose frame is 4,800 clocks long. That instance passes through several complete frames, including one with the external stream toggling inside the window. The full-size instance is run far enough to show its 508-clock lines, its vertical sync lines and its first visible lines, with a reset placed part-way through the frame.

// File: rtl/cvid_pkg.sv
// Package: shared level codes for the composite timing generator.
// Assumes an external three-level resistor network decodes the two bits.
package cvid_pkg;
    typedef enum logic [1:0] {
        LVL_SYNC  = 2'b00,
        LVL_BLACK = 2'b01,
        LVL_WHITE = 2'b11
    } level_e;
endpackage

// File: rtl/cvid_hcount.sv
// Horizontal counter: counts clocks within one scan line and flags the
// last clock of the line. Assumes LINE_CLKS >= 2.
module cvid_hcount #(
    parameter int LINE_CLKS = 508,
    localparam int PIX_W = $clog2(LINE_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PIX_W-1:0] pix_o,
    output logic             eol_o
);
    localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(LINE_CLKS - 1);

    // Purpose: end-of-line flag for the line counter.
    always_comb begin
        eol_o = (pix_o == LAST_PIX);
    end

    // Purpose: advance the pixel position, wrapping at the line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_o <= '0;
        end else if (eol_o) begin
            pix_o <= '0;
        end else begin
            pix_o <= pix_o + 1'b1;
        end
    end

    AST_PIX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_o <= LAST_PIX); // R2
    AST_PIX_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_o == LAST_PIX) |=> (pix_o == '0)); // R2
    AST_PIX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_o != LAST_PIX) |=> (pix_o == $past(pix_o) + 1'b1)); // R2
endmodule

// File: rtl/cvid_vcount.sv
// Vertical counter: counts scan lines within the frame, stepping once per
// line-end strobe. Assumes FRAME_LINES >= 2.
module cvid_vcount #(
    parameter int FRAME_LINES = 525,
    localparam int LINE_W = $clog2(FRAME_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    output logic [LINE_W-1:0] line_o
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(FRAME_LINES - 1);

    // Purpose: advance the line number at each line end, wrapping per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o <= '0;
        end else if (step_i) begin
            if (line_o == LAST_LINE) begin
                line_o <= '0;
            end else begin
                line_o <= line_o + 1'b1;
            end
        end
    end

    AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        line_o <= LAST_LINE); // R3
    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(line_o)); // R3
    AST_FRAME_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && line_o == LAST_LINE) |=> (line_o == '0)); // R3
endmodule

// File: rtl/cvid_level_dec.sv
// Level decoder: maps the beam position and the pixel source onto a
// composite level code. Pure combinational logic that follows the counters.
// Assumes the pixel and line counters are wider than CELL_BIT.
module cvid_level_dec
    import cvid_pkg::*;
#(
    parameter int LINE_CLKS    = 508,
    parameter int FRAME_LINES  = 525,
    parameter int HSYNC_CLKS   = 38,
    parameter int BPORCH_CLKS  = 38,
    parameter int ACTIVE_CLKS  = 416,
    parameter int VSYNC_LINES  = 3,
    parameter int VTOP_LINES   = 20,
    parameter int ACTIVE_LINES = 480,
    parameter int CELL_BIT     = 5,
    localparam int PIX_W  = $clog2(LINE_CLKS),
    localparam int LINE_W = $clog2(FRAME_LINES)
) (
    input  logic [PIX_W-1:0]  pix_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              ext_en_i,
    input  logic              ext_white_i,
    output level_e            level_o
);
    localparam logic [PIX_W-1:0]  HS_END   = PIX_W'(HSYNC_CLKS);
    localparam logic [PIX_W-1:0]  SERR_END = PIX_W'(LINE_CLKS - HSYNC_CLKS);
    localparam logic [PIX_W-1:0]  HACT_S   = PIX_W'(HSYNC_CLKS + BPORCH_CLKS);
    localparam logic [PIX_W-1:0]  HACT_E   = PIX_W'(HSYNC_CLKS + BPORCH_CLKS + ACTIVE_CLKS);
    localparam logic [LINE_W-1:0] VS_END   = LINE_W'(VSYNC_LINES);
    localparam logic [LINE_W-1:0] VACT_S   = LINE_W'(VTOP_LINES);
    localparam logic [LINE_W-1:0] VACT_E   = LINE_W'(VTOP_LINES + ACTIVE_LINES);

    logic in_vsync, in_hsync, in_window, cell_white;

    // Purpose: classify the beam position into timing regions.
    always_comb begin
        in_vsync   = (line_i < VS_END);
        in_hsync   = (pix_i < HS_END);
        in_window  = (pix_i >= HACT_S) && (pix_i < HACT_E) &&
                     (line_i >= VACT_S) && (line_i < VACT_E);
        cell_white = pix_i[CELL_BIT] ^ line_i[CELL_BIT];
    end

    // Purpose: choose the output level by region priority.
    always_comb begin
        if (in_vsync) begin
            level_o = (pix_i < SERR_END) ? LVL_SYNC : LVL_BLACK;
        end else if (in_hsync) begin
            level_o = LVL_SYNC;
        end else if (in_window) begin
            if (ext_en_i) begin
                level_o = ext_white_i ? LVL_WHITE : LVL_BLACK;
            end else begin
                level_o = cell_white ? LVL_WHITE : LVL_BLACK;
            end
        end else begin
            level_o = LVL_BLACK;
        end
    end

    always_comb begin
        AST_CODE_LEGAL: assert (level_o != 2'b10); // R1
    end
endmodule

// File: rtl/cvid_timing_gen.sv
// Composite monochrome video timing generator (top). Chains the pixel
// counter, the line counter and the level decoder. Assumes a fixed system
// clock; the default geometry targets 8 MHz, 508 clocks per line, 525 lines.
module cvid_timing_gen
    import cvid_pkg::*;
#(
    parameter int LINE_CLKS    = 508,
    parameter int FRAME_LINES  = 525,
    parameter int HSYNC_CLKS   = 38,
    parameter int BPORCH_CLKS  = 38,
    parameter int ACTIVE_CLKS  = 416,
    parameter int VSYNC_LINES  = 3,
    parameter int VTOP_LINES   = 20,
    parameter int ACTIVE_LINES = 480,
    localparam int PIX_W  = $clog2(LINE_CLKS),
    localparam int LINE_W = $clog2(FRAME_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_en_i,
    input  logic              ext_white_i,
    output logic [1:0]        level_o,
    output logic [LINE_W-1:0] line_o,
    output logic [PIX_W-1:0]  pix_o
);
    localparam logic [PIX_W-1:0]  HS_END = PIX_W'(HSYNC_CLKS);
    localparam logic [LINE_W-1:0] VS_END = LINE_W'(VSYNC_LINES);

    logic   eol;
    level_e level;

    cvid_hcount #(.LINE_CLKS(LINE_CLKS)) u_hcount (
        .clk   (clk),
        .rst_n (rst_n),
        .pix_o (pix_o),
        .eol_o (eol)
    );

    cvid_vcount #(.FRAME_LINES(FRAME_LINES)) u_vcount (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (eol),
        .line_o (line_o)
    );

    cvid_level_dec #(
        .LINE_CLKS   (LINE_CLKS),
        .FRAME_LINES (FRAME_LINES),
        .HSYNC_CLKS  (HSYNC_CLKS),
        .BPORCH_CLKS (BPORCH_CLKS),
        .ACTIVE_CLKS (ACTIVE_CLKS),
        .VSYNC_LINES (VSYNC_LINES),
        .VTOP_LINES  (VTOP_LINES),
        .ACTIVE_LINES(ACTIVE_LINES),
        .CELL_BIT    (5)
    ) u_dec (
        .pix_i       (pix_o),
        .line_i      (line_o),
        .ext_en_i    (ext_en_i),
        .ext_white_i (ext_white_i),
        .level_o     (level)
    );

    // Purpose: present the decoded level as a plain 2-bit code.
    always_comb begin
        level_o = level;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pix_o == '0 && line_o == '0)); // R4
    AST_HSYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o >= VS_END && pix_o < HS_END) |-> (level_o == 2'b00)); // R5
    AST_VSYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o < VS_END && pix_o == '0) |-> (level_o == 2'b00)); // R6
endmodule

// File: tb/cvid_timing_gen_tb_top.sv
// Bench: behavioural per-clock model of the counters and levels, compared
// against a full-size instance and a reduced-geometry instance.
module cvid_timing_gen_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_en = 1'b0;
    logic ext_white = 1'b0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    // full-size instance
    logic [1:0] lvl_d;
    logic [9:0] line_d;
    logic [8:0] pix_d;
    cvid_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .ext_en_i(ext_en), .ext_white_i(ext_white),
        .level_o(lvl_d), .line_o(line_d), .pix_o(pix_d)
    );

    // reduced instance: 120 clocks per line, 40 lines per frame
    logic [1:0] lvl_s;
    logic [5:0] line_s;
    logic [6:0] pix_s;
    cvid_timing_gen #(
        .LINE_CLKS(120), .FRAME_LINES(40), .HSYNC_CLKS(10), .BPORCH_CLKS(10),
        .ACTIVE_CLKS(90), .VSYNC_LINES(3), .VTOP_LINES(6), .ACTIVE_LINES(30)
    ) dut_s (
        .clk(clk), .rst_n(rst_n), .ext_en_i(ext_en), .ext_white_i(ext_white),
        .level_o(lvl_s), .line_o(line_s), .pix_o(pix_s)
    );

    // Expected level and the requirement tag behind it.
    function automatic int exp_level(input int p, input int l, input int lc,
                                     input int hs, input int bp, input int act,
                                     input int vs, input int vt, input int va,
                                     input bit en, input bit wh,
                                     output string tag);
        if (l < vs) begin
            tag = "R6";
            return (p < lc - hs) ? 0 : 1;
        end
        if (p < hs) begin
            tag = "R5";
            return 0;
        end
        if (p >= hs + bp && p < hs + bp + act && l >= vt && l < vt + va) begin
            if (en) begin
                tag = "R9";
                return wh ? 3 : 1;
            end
            tag = "R8";
            return ((((p / 32) % 2) ^ ((l / 32) % 2)) != 0) ? 3 : 1;
        end
        tag = "R7";
        return 1;
    endfunction

    task automatic check(input string who, input string tag, input int act_v, input int exp_v);
        total++;
        if (act_v != exp_v) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, who, act_v, exp_v, $time);
        end
    endtask

    initial begin
        int mp_d = 0, ml_d = 0, mp_s = 0, ml_s = 0;
        bit rst_seen = 1'b1;
        string tag;
        int e;
        for (int n = 0; n < 22000; n++) begin
            @(negedge clk);
            // R4 tags counter checks right after a reset edge; R2/R3 otherwise
            check("pix full",  rst_seen ? "R4" : "R2", int'(pix_d),  mp_d);
            check("line full", rst_seen ? "R4" : "R3", int'(line_d), ml_d);
            check("pix small", rst_seen ? "R4" : "R2", int'(pix_s),  mp_s);
            check("line small", rst_seen ? "R4" : "R3", int'(line_s), ml_s);
            e = exp_level(mp_d, ml_d, 508, 38, 38, 416, 3, 20, 480, ext_en, ext_white, tag);
            check("level full", tag, int'(lvl_d), e);
            check("code legal full R1", "R1", int'(lvl_d == 2'b10), 0);
            e = exp_level(mp_s, ml_s, 120, 10, 10, 90, 3, 6, 30, ext_en, ext_white, tag);
            check("level small", tag, int'(lvl_s), e);
            check("code legal small R1", "R1", int'(lvl_s == 2'b10), 0);
            // next-cycle inputs: reset at start and mid-run, external stream in frame 2
            rst_n = !(n < 1 || (n >= 9000 && n < 9003));
            ext_en = (n >= 4800 && n < 9600);
            ext_white = ((n / 7) % 2) == 1;
            // advance model to the state after the next rising edge
            rst_seen = !rst_n;
            if (!rst_n) begin
                mp_d = 0; ml_d = 0; mp_s = 0; ml_s = 0;
            end else begin
                if (mp_d == 507) begin mp_d = 0; ml_d = (ml_d == 524) ? 0 : ml_d + 1; end
                else mp_d++;
                if (mp_s == 119) begin mp_s = 0; ml_s = (ml_s == 39) ? 0 : ml_s + 1; end
                else mp_s++;
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(300000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule